// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block is the processor-side engine for a 20-bit bus whose low 16 lines carry the address and the data at different times. A single request carries the access direction, a memory-or-I/O select, a 2-bit segment class, a 20-bit address and write data. The request starts one bus cycle through the phases T1, T2, T3, any number of wait phases Tw, and T4. During the cycle the block drives the latch strobe, the direction and enable controls for an external transceiver, and the read and write strobes. It also drives the top four address lines, which carry address in T1 and status from T2 onward.

An external `ready` input stretches the cycle. It is sampled at the clock edge that ends T3 and at the edge that ends each Tw. Read data arriving on the low lines is captured as the cycle enters T4, and `done` marks T4. A new request may start in the cycle that follows T4, so accesses can run back to back without an idle phase.

Top module: `bus_cycle_seq`

## Requirements
- R1: Out of reset the block is idle: `busy`, `ale`, `rd`, `wr`, `den`, `done`, `dtr`, `mio` and `ad_oe` are all low, and `a_hi` is 0.
- R2: In T1, the first cycle after a request is accepted, `ale` is high, `ad_oe` is high, `ad_out` carries address bits 15..0, and `a_hi` carries address bits 19..16.
- R3: From T2 through T4, `a_hi` carries status. Bit 3 is always 0. Bit 2 is the `int_en` value latched when the request was accepted. Bits 1..0 are the segment class, coded 00 extra, 01 stack, 10 code/none, 11 data.
- R4: A cycle runs T1, T2, T3, then one Tw for every clock edge at the end of T3 or Tw where `ready` is low, then T4. With `ready` high at the end of T3 there are no waits.
- R5: For a read (`req_write`=0), `dtr` is low for the whole cycle. `rd` and `den` are high in T2, T3 and every Tw, and `ad_oe` is low in those phases. `rdata` holds the `ad_in` value sampled at the edge that enters T4.
- R6: For a write (`req_write`=1), `dtr` is high from T1 through T4. `wr` and `den` are high in T2, T3 and every Tw, and in those phases `ad_oe` is high with `ad_out` equal to the write data.
- R7: In T4, `rd`, `wr`, `den` and `ad_oe` are low and `done` is high. `done` lasts exactly one cycle per bus cycle.
- R8: `mio` is high from T1 through T4 for a memory access and low for an I/O access.
- R9: A request is accepted only when the block is idle or in T4. A request raised during T1 to Tw is ignored and does not change the cycle in progress. A request present in T4 starts T1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_seg | input | 2 | Segment class for status bits |
| req_addr | input | 20 | Physical address |
| req_wdata | input | 16 | Write data |
| int_en | input | 1 | Interrupt-enable flag to report in status |
| ready | input | 1 | Ends wait phases when high |
| ad_in | input | 16 | Data read from the low bus lines |
| ad_out | output | 16 | Value driven on the low bus lines |
| ad_oe | output | 1 | Drive enable for the low bus lines |
| a_hi | output | 4 | Upper address / status lines |
| ale | output | 1 | Address latch strobe |
| mio | output | 1 | 1 = memory cycle |
| dtr | output | 1 | Transceiver direction, 1 = transmit |
| den | output | 1 | Transceiver enable |
| rd | output | 1 | Read strobe |
| wr | output | 1 | Write strobe |
| done | output | 1 | High in T4 |
| busy | output | 1 | High while a cycle is in progress |
| rdata | output | 16 | Captured read data |

## Verification
A request set up at a falling edge is taken at the next rising edge, so T1 is the cycle that follows and T2, T3, Tw and T4 come one per edge after it. Each bench task counts cycles from the request. It checks every output at the falling edge of each phase, with that phase's expected values worked out from the requirement rules above. `ready` is changed only at falling edges, so it decides the edge that ends T3 or Tw. `rdata` is checked in the T4 cycle, one edge after that deciding sample.

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_io,
  input  logic [1:0]    req_seg,
  input  logic [DW+3:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          int_en,
  input  logic          ready,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic [3:0]    a_hi,
  output logic          ale,
  output logic          mio,
  output logic          dtr,
  output logic          den,
  output logic          rd,
  output logic          wr,
  output logic          done,
  output logic          busy,
  output logic [DW-1:0] rdata
);
  localparam int AW = DW + 4;

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_T3, S_TW, S_T4} st_t;
  st_t st;

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q;
  logic          wr_q, io_q, ie_q;
  logic [1:0]    seg_q;

  wire accept = req_valid && (st == S_IDLE || st == S_T4);
  wire mid    = (st == S_T3) || (st == S_TW);
  wire strobe = (st == S_T2) || mid;
  wire active = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      addr_q <= '0;
      wd_q   <= '0;
      wr_q   <= 1'b0;
      io_q   <= 1'b0;
      ie_q   <= 1'b0;
      seg_q  <= '0;
      rdata  <= '0;
    end else begin
      if (accept) begin
        addr_q <= req_addr;
        wd_q   <= req_wdata;
        wr_q   <= req_write;
        io_q   <= req_io;
        ie_q   <= int_en;
        seg_q  <= req_seg;
      end
      if (mid && ready && !wr_q) rdata <= ad_in;
      case (st)
        S_IDLE:       st <= accept ? S_T1 : S_IDLE;
        S_T1:         st <= S_T2;
        S_T2:         st <= S_T3;
        S_T3, S_TW:   st <= ready ? S_T4 : S_TW;
        S_T4:         st <= accept ? S_T1 : S_IDLE;
        default:      st <= S_IDLE;
      endcase
    end
  end

  assign ale    = (st == S_T1);
  assign ad_oe  = ale || (wr_q && strobe);
  assign ad_out = ale ? addr_q[DW-1:0] : ((wr_q && strobe) ? wd_q : '0);
  assign a_hi   = ale ? addr_q[AW-1:DW] : (active ? {1'b0, ie_q, seg_q} : 4'b0);
  assign mio    = active && !io_q;
  assign dtr    = active && wr_q;
  assign den    = strobe;
  assign rd     = strobe && !wr_q;
  assign wr     = strobe && wr_q;
  assign done   = (st == S_T4);
  assign busy   = active;

  p_ale_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (!rd && !wr && !den && !done));
  p_s6_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ale) |-> (a_hi[3] == 1'b0));
  p_status_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (den && $past(den)) |-> $stable(a_hi));
  p_wait_stretch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (den && !ale && $past(den) && !ready) |=> den);
  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd && wr));
  p_done_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(den) && !den && !ad_oe));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/bus_cycle_seq_tb_top.sv
module bus_cycle_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_io, int_en, ready;
  logic [1:0]  req_seg;
  logic [19:0] req_addr;
  logic [15:0] req_wdata, ad_in;
  logic [15:0] ad_out, rdata;
  logic [3:0]  a_hi;
  logic        ad_oe, ale, mio, dtr, den, rd, wr, done, busy;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bus_cycle_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_io(req_io), .req_seg(req_seg), .req_addr(req_addr), .req_wdata(req_wdata),
    .int_en(int_en), .ready(ready), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .a_hi(a_hi), .ale(ale), .mio(mio), .dtr(dtr), .den(den), .rd(rd), .wr(wr),
    .done(done), .busy(busy), .rdata(rdata)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic present(input logic w, input logic io, input logic [1:0] seg,
                         input logic [19:0] a, input logic [15:0] d, input logic ie);
    req_valid = 1'b1; req_write = w; req_io = io; req_seg = seg;
    req_addr = a; req_wdata = d; int_en = ie;
  endtask

  // Runs from the falling edge where the request is presented; returns at the T4 falling edge
  // (or the following idle one when ends_idle is set).
  task automatic run_cycle(input logic w, input logic io, input logic [1:0] seg,
                           input logic [19:0] a, input logic [15:0] d, input logic ie,
                           input int waits, input logic [15:0] rdv, input bit spurious,
                           input bit ends_idle);
    logic [3:0] st;
    for (int i = 1; i <= 4 + waits; i++) begin
      @(negedge clk);
      if (i == 1) req_valid = 1'b0;
      if (spurious && i == 2) present(~w, ~io, ~seg, ~a, ~d, ~ie);
      if (spurious && i == 3) req_valid = 1'b0;
      ready = !(i >= 3 && i <= 2 + waits);
      ad_in = rdv;
      st = {1'b0, ie, seg};
      chk("R8", "mio", mio, !io);
      chk(w ? "R6" : "R5", "dtr", dtr, w);
      if (i == 1) begin
        chk("R2", "ale/oe/strobes", {ale, ad_oe, rd, wr, den, done}, 6'b110000);
        chk("R2", "ad_out", ad_out, a[15:0]);
        chk("R2", "a_hi", a_hi, a[19:16]);
      end else if (i < 4 + waits) begin
        chk("R4", "phase strobes", {ale, den, done}, 3'b010);
        chk(w ? "R6" : "R5", "rd/wr/oe", {rd, wr, ad_oe}, w ? 3'b011 : 3'b100);
        if (w) chk("R6", "ad_out", ad_out, d);
        chk("R3", "status", a_hi, st);
      end else begin
        chk("R7", "T4 outputs", {ale, rd, wr, den, ad_oe, done}, 6'b000001);
        chk("R3", "status T4", a_hi, st);
        if (!w) chk("R5", "rdata", rdata, rdv);
      end
    end
    ready = 1'b1;
    if (ends_idle) begin
      @(negedge clk);
      chk("R7", "idle after T4", {busy, done, den, ale}, 4'b0000);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_io = 1'b0; req_seg = 2'b00;
    req_addr = '0; req_wdata = '0; int_en = 1'b0; ready = 1'b1; ad_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "reset outputs", {busy, ale, rd, wr, den, done, dtr, mio, ad_oe}, 9'b0);
    chk("R1", "reset a_hi", a_hi, 4'h0);
  endtask

  task automatic t_read_nowait;
    present(1'b0, 1'b0, 2'b11, 20'hA5C3E, 16'h0, 1'b1);
    run_cycle(1'b0, 1'b0, 2'b11, 20'hA5C3E, 16'h0, 1'b1, 0, 16'hBEEF, 1'b0, 1'b1);
  endtask

  task automatic t_write_waits;
    present(1'b1, 1'b0, 2'b01, 20'h3F00D, 16'h1234, 1'b0);
    run_cycle(1'b1, 1'b0, 2'b01, 20'h3F00D, 16'h1234, 1'b0, 3, 16'h0, 1'b0, 1'b1);
  endtask

  task automatic t_io_read_wait;
    present(1'b0, 1'b1, 2'b10, 20'h00380, 16'h0, 1'b0);
    run_cycle(1'b0, 1'b1, 2'b10, 20'h00380, 16'h0, 1'b0, 1, 16'h5AA5, 1'b0, 1'b1);
  endtask

  task automatic t_ignore_busy_req;
    present(1'b1, 1'b1, 2'b00, 20'hC0001, 16'h8001, 1'b1);
    run_cycle(1'b1, 1'b1, 2'b00, 20'hC0001, 16'h8001, 1'b1, 2, 16'h0, 1'b1, 1'b1);
    chk("R9", "no extra cycle", busy, 1'b0);
  endtask

  task automatic t_back_to_back;
    present(1'b1, 1'b0, 2'b10, 20'hFFFFF, 16'hFFFF, 1'b1);
    run_cycle(1'b1, 1'b0, 2'b10, 20'hFFFFF, 16'hFFFF, 1'b1, 0, 16'h0, 1'b0, 1'b0);
    present(1'b0, 1'b0, 2'b00, 20'h10002, 16'h0, 1'b0);
    run_cycle(1'b0, 1'b0, 2'b00, 20'h10002, 16'h0, 1'b0, 2, 16'h0F0F, 1'b0, 1'b1);
    chk("R9", "chained read data", rdata, 16'h0F0F);
  endtask

  initial begin
    t_reset();
    t_read_nowait();
    t_write_waits();
    t_io_read_wait();
    t_ignore_busy_req();
    t_back_to_back();
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule